// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles the even-parity duties of a 32-bit PCI target. Whenever the target places read data on the shared address/data lines, the block registers the parity of that data and of the byte-enable lines. It then presents the result on PAR in the following clock, together with an output enable that trails the data enable by one clock.

The block also checks parity on data that other agents send to it. For every address phase and every received write data phase, it computes the parity that the PAR line ought to carry. One clock later it compares that value with the PAR value seen on the bus.

- A mismatch on write data drives PERR# low two clocks after the data phase, but only when the parity-error-response bit is set. PERR# is a sustained tri-state line, so it is driven high for one clock before it is released.
- A mismatch on an address phase produces a single-clock open-drain pull on SERR#, but only when both the SERR# enable bit and the parity-error-response bit are set.
- Every mismatch also produces a status pulse for the configuration space, whatever the enable bits say.

The block expects the bus-facing logic to feed it the sampled bus values and the phase strobes. It expects a reset that has already been released synchronously to `clk`.

Top module: `pci_parity_unit`

## Requirements
- R1: When `ad_drv_oe_i` is high in a cycle, `par_o` in the next cycle makes the total count of ones across `ad_bus_i`, `cbe_bus_i` (from that cycle) and `par_o` even.
- R2: `par_oe_o` in a cycle equals `ad_drv_oe_i` of the previous cycle.
- R3: When `wdat_vld_i` is high in cycle c, `par_bus_i` of cycle c+1 is compared with the even parity of the cycle-c bus values. On a mismatch with `per_en_i` high in cycle c+1, `perr_n_o` is 0 with `perr_oe_o` 1 in cycle c+2.
- R4: PERR# is low exactly in the cycles named by R3. Consecutive erroring data phases hold it low without a gap. Without an error it is never low.
- R5: After each run of low cycles, `perr_oe_o` stays 1 with `perr_n_o` at 1 for exactly one cycle, unless a new error drives it low in that cycle. After that cycle `perr_oe_o` returns to 0.
- R6: With `per_en_i` low in the PAR cycle, a data parity mismatch leaves `perr_oe_o` at 0.
- R7: When `addr_vld_i` is high in cycle c and `par_bus_i` of cycle c+1 mismatches, `serr_oe_o` is 1 for the single cycle c+2. This happens only if `serr_en_i` and `per_en_i` are both high in cycle c+1. SERR# has no high-driving output.
- R8: `stat_det_perr_o` is 1 in cycle c+2 for any address or data mismatch of R3/R7, regardless of `per_en_i` and `serr_en_i`.
- R9: While `rst_n` is low, `par_oe_o`, `perr_oe_o`, `serr_oe_o` and `stat_det_perr_o` are 0, and checks pending at reset are discarded.
- R10: `par_bus_i` in a cycle that follows neither an address phase nor a received data phase has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_bus_i | input | 32 | Value on the address/data lines this cycle |
| cbe_bus_i | input | 4 | Value on the command/byte-enable lines (active-low encoding, taken as seen) |
| par_bus_i | input | 1 | PAR as sampled from the bus |
| addr_vld_i | input | 1 | This cycle is an address phase addressed to the check |
| wdat_vld_i | input | 1 | This cycle completes a data phase received by this agent |
| ad_drv_oe_i | input | 1 | This agent drives the address/data lines this cycle |
| per_en_i | input | 1 | Parity-error-response command bit |
| serr_en_i | input | 1 | SERR# enable command bit |
| par_o | output | 1 | Generated parity value |
| par_oe_o | output | 1 | Drive enable for PAR |
| perr_n_o | output | 1 | PERR# value when driven |
| perr_oe_o | output | 1 | Drive enable for PERR# |
| serr_oe_o | output | 1 | Open-drain pull-low enable for SERR# |
| stat_det_perr_o | output | 1 | Detected-parity-error status pulse |

## Verification
Several stimulus patterns are used, and each one separates a different kind of fault:
- Sparse single errors with both enables set separate the two-clock PERR# latency and the one-clock high release from off-by-one delays.
- Runs of back-to-back erroring write phases show whether PERR# stays continuously low or wrongly inserts a high cycle between errors.
- Windows with the response bit clear, and windows with only the SERR# enable clear, tell the gating of PERR# and SERR# apart from the ungated status pulse.
- Random PAR values in cycles after no strobe show that unchecked cycles are ignored.
- Mid-run resets show that pending checks are dropped.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  typedef enum logic [1:0] {
    PERR_IDLE = 2'd0,
    PERR_LOW  = 2'd1,
    PERR_HIGH = 2'd2
  } perr_st_e;

  typedef struct packed {
    logic addr;
    logic data;
    logic exp_par;
  } chk_pend_t;

endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_i,
  input  logic              drv_oe_i,
  output logic              par_o,
  output logic              par_oe_o
);

  logic par_q, par_d;
  logic oe_q;

  // even parity: par makes the total ones count even
  always_comb begin
    par_d = ^{ad_i, cbe_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= drv_oe_i;
      if (drv_oe_i) begin
        par_q <= par_d;
      end
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

  AST_PAR_OE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe_i |=> par_oe_o); // R2

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe_i |=> ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0)); // R1

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
  import pci_par_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_i,
  input  logic              par_i,
  input  logic              addr_vld_i,
  input  logic              wdat_vld_i,
  output logic              addr_mis_o,
  output logic              data_mis_o
);

  chk_pend_t pend_q, pend_d;
  logic      mis;

  always_comb begin
    pend_d.addr    = addr_vld_i;
    pend_d.data    = wdat_vld_i;
    pend_d.exp_par = ^{ad_i, cbe_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // PAR for a phase arrives one clock after that phase
  always_comb begin
    mis        = pend_q.exp_par ^ par_i;
    addr_mis_o = pend_q.addr & mis;
    data_mis_o = pend_q.data & mis;
  end

endmodule

// File: rtl/pci_perr_drv.sv
module pci_perr_drv
  import pci_par_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  output logic perr_n_o,
  output logic perr_oe_o
);

  perr_st_e st_q, st_d;

  always_comb begin
    st_d = PERR_IDLE;
    if (err_i) begin
      st_d = PERR_LOW;
    end else if (st_q == PERR_LOW) begin
      st_d = PERR_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PERR_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign perr_oe_o = (st_q != PERR_IDLE);
  assign perr_n_o  = (st_q != PERR_LOW);

  // sustained tri-state: a low cycle is never followed directly by release
  AST_PERR_HIGH_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe_o && !perr_n_o) |=> perr_oe_o); // R5

  AST_PERR_FLOAT_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe_o && perr_n_o && !err_i) |=> !perr_oe_o); // R5

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_bus_i,
  input  logic [CBE_W-1:0]  cbe_bus_i,
  input  logic              par_bus_i,
  input  logic              addr_vld_i,
  input  logic              wdat_vld_i,
  input  logic              ad_drv_oe_i,
  input  logic              per_en_i,
  input  logic              serr_en_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              perr_n_o,
  output logic              perr_oe_o,
  output logic              serr_oe_o,
  output logic              stat_det_perr_o
);

  logic addr_mis, data_mis;
  logic perr_req;
  logic serr_q, serr_d;
  logic det_q, det_d;

  pci_par_gen #(.DATA_W(DATA_W), .CBE_W(CBE_W)) gen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad_i     (ad_bus_i),
    .cbe_i    (cbe_bus_i),
    .drv_oe_i (ad_drv_oe_i),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  pci_par_chk #(.DATA_W(DATA_W), .CBE_W(CBE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_i       (ad_bus_i),
    .cbe_i      (cbe_bus_i),
    .par_i      (par_bus_i),
    .addr_vld_i (addr_vld_i),
    .wdat_vld_i (wdat_vld_i),
    .addr_mis_o (addr_mis),
    .data_mis_o (data_mis)
  );

  assign perr_req = data_mis & per_en_i;

  pci_perr_drv perr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_i     (perr_req),
    .perr_n_o  (perr_n_o),
    .perr_oe_o (perr_oe_o)
  );

  always_comb begin
    serr_d = addr_mis & serr_en_i & per_en_i;
    det_d  = addr_mis | data_mis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      serr_q <= serr_d;
      det_q  <= det_d;
    end
  end

  assign serr_oe_o       = serr_q;
  assign stat_det_perr_o = det_q;

  AST_SERR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mis && !(serr_en_i && per_en_i)) |=> !serr_oe_o); // R7

  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mis && !per_en_i) |=> perr_n_o); // R6

  AST_STATUS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mis || data_mis) |=> stat_det_perr_o); // R8

endmodule

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb_top;

  localparam int NCYC = 1600;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad_bus;
  logic [3:0]  cbe_bus;
  logic        par_bus, addr_vld, wdat_vld, ad_drv_oe, per_en, serr_en;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o, serr_oe_o, stat_det_perr_o;

  int vectors = 0;
  int errors  = 0;

  bit          rst_a [NCYC];
  bit          oe_a  [NCYC];
  bit          av_a  [NCYC];
  bit          dv_a  [NCYC];
  bit          per_a [NCYC];
  bit          se_a  [NCYC];
  bit          pb_a  [NCYC];
  bit          low_a [NCYC];
  logic [31:0] ad_a  [NCYC];
  logic [3:0]  cbe_a [NCYC];

  always #10 clk = ~clk;

  pci_parity_unit dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .ad_bus_i        (ad_bus),
    .cbe_bus_i       (cbe_bus),
    .par_bus_i       (par_bus),
    .addr_vld_i      (addr_vld),
    .wdat_vld_i      (wdat_vld),
    .ad_drv_oe_i     (ad_drv_oe),
    .per_en_i        (per_en),
    .serr_en_i       (serr_en),
    .par_o           (par_o),
    .par_oe_o        (par_oe_o),
    .perr_n_o        (perr_n_o),
    .perr_oe_o       (perr_oe_o),
    .serr_oe_o       (serr_oe_o),
    .stat_det_perr_o (stat_det_perr_o)
  );

  function automatic bit odd_ones(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) if (a[i]) n++;
    for (int i = 0; i < 4; i++) if (c[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic check(input string tag, input int k, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, k, act, exp);
    end
  endtask

  // reference model: outputs seen at negedge k reflect inputs up to cycle k-1
  task automatic compare(input int k);
    bit r1, am, dm, low, exp_oe;
    r1  = rst_a[k-1];
    dm  = dv_a[k-2] && (odd_ones(ad_a[k-2], cbe_a[k-2]) != pb_a[k-1]);
    am  = av_a[k-2] && (odd_ones(ad_a[k-2], cbe_a[k-2]) != pb_a[k-1]);
    low = !r1 && per_a[k-1] && dm;
    low_a[k] = low;
    exp_oe = !r1 && oe_a[k-1];
    check(r1 ? "R9 par_oe" : "R2 par_oe", k, par_oe_o, exp_oe);
    if (exp_oe)
      check("R1 par", k, par_o, odd_ones(ad_a[k-1], cbe_a[k-1]));
    check(r1 ? "R9 perr_oe" : "R5 perr_oe", k, perr_oe_o, low || (low_a[k-1] && !r1));
    if (perr_oe_o === 1'b1)
      check(per_a[k-1] ? "R3 R4 perr_n" : "R6 perr_n", k, perr_n_o, !low);
    check(r1 ? "R9 serr_oe" : "R7 serr_oe", k, serr_oe_o, !r1 && am && se_a[k-1] && per_a[k-1]);
    check(r1 ? "R9 stat" : "R8 R10 stat", k, stat_det_perr_o, !r1 && (am || dm));
  endtask

  initial begin : watchdog
    repeat (NCYC * 4) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; ad_bus = '0; cbe_bus = '0; par_bus = 1'b0;
    addr_vld = 1'b0; wdat_vld = 1'b0; ad_drv_oe = 1'b0; per_en = 1'b0; serr_en = 1'b0;
    for (int k = 0; k < NCYC; k++) begin
      int sel, flip_w;
      bit rst, flip;
      @(negedge clk);
      if (k >= 2) compare(k);
      rst = (k < 4) || (k >= 800 && k < 806) || (k >= 1200 && k < 1203);
      rst_a[k] = rst;
      ad_a[k]  = $urandom;
      cbe_a[k] = 4'($urandom);
      sel = $urandom_range(0, 3);
      oe_a[k]  = !rst && ($urandom_range(0, 1) == 1);
      av_a[k]  = !rst && (sel == 1);
      dv_a[k]  = !rst && (sel >= 2);
      per_a[k] = 1'b1; se_a[k] = 1'b1; flip_w = 4;
      if (k >= 200 && k < 400) per_a[k] = ($urandom_range(0, 3) == 0);
      else if (k >= 400 && k < 600) se_a[k] = 1'b0;
      else if (k >= 900) begin
        per_a[k] = $urandom_range(0, 1); se_a[k] = $urandom_range(0, 1); flip_w = 2;
      end
      if (k >= 600 && k < 800) begin
        dv_a[k] = !rst; av_a[k] = 1'b0; flip_w = 2;
      end
      flip = ($urandom_range(0, flip_w - 1) == 0);
      pb_a[k] = (k == 0) ? 1'b0 : (odd_ones(ad_a[k-1], cbe_a[k-1]) ^ flip);
      if (k < 2) low_a[k] = 1'b0;
      rst_n     = !rst;
      ad_bus    = ad_a[k];
      cbe_bus   = cbe_a[k];
      par_bus   = pb_a[k];
      addr_vld  = av_a[k];
      wdat_vld  = dv_a[k];
      ad_drv_oe = oe_a[k];
      per_en    = per_a[k];
      serr_en   = se_a[k];
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule